// File: doc/BRIEF.md
# PCI Configuration Cycle Request Unit

This block sits on the host side of a PCI bridge and turns simple software register accesses into single configuration transactions. Two request paths exist. The bus path reaches devices behind the bridge. Software loads a device locator and then a command. The block forms a type-0 or type-1 configuration address from the locator. The local path reaches the bridge's own configuration space and uses a separate control word. On both paths the block works out the active-low byte enables from the access size and the low two address bits. It rejects any size and offset pair that does not fit a naturally aligned byte, halfword or word.

Each accepted request appears downstream as a one-cycle request pulse. The pulse carries the address, byte enables, command and write data. The block then waits for a single response, which may report a master abort. Only one transaction can be outstanding at a time. A second request that arrives while busy is dropped and recorded as an error.

Two error status registers are cleared by writing a one to a bit. The first records bus-side failures and the second records failures reported by the local fabric. Each has a companion register that latches the failing address. Write data must already sit on its byte lane. Read data comes back as the full dword, without shifting. A register read returns its data on reg_rdata in the cycle after reg_rd is sampled.

Top module: `pcfg_req_top`

## Requirements
- R1: After a synchronous reset, every register reads zero, busy is 0 and dn_req_valid is 0. A read sampled at one clock edge presents its data on reg_rdata after that edge.
- R2: Byte enables are active-low. Size code 0 (byte) at offset 0/1/2/3 gives 0xE/0xD/0xB/0x7. Size code 1 (halfword) at offset 0 gives 0xC and at offset 2 gives 0x3. Size code 2 (word) at offset 0 gives 0x0. Every other pair, including size code 3, sets the reject flag and starts no transaction.
- R3: The bus command register at 0x10 holds the command in bits 3:0, the byte enables in bits 7:4, the size in bits 9:8 and the reject flag in bit 15. Writing it with command 0xA starts a bus read. Command 0xB starts nothing by itself: a bus write starts when 0x14 is written while the register holds 0xB and is not rejected. Any other command starts nothing. The command is driven on dn_req_cmd.
- R4: With bus number 0 in the locator at 0x0C (bus 23:16, device 15:11, function 10:8, byte offset 7:0), the request address is (1 << device) OR (function << 8) OR the offset with its low two bits cleared.
- R5: With a non-zero bus number, the request address is bus in 23:16, device in 15:11, function in 10:8, dword offset in 7:2, bit 1 = 0 and bit 0 = 1.
- R6: The local control word at 0x00 takes an offset in bits 7:0, write select in bit 16 and size in bits 25:24. It reads back the dword offset in 7:2, write in 16, byte enables in 23:20, size in 25:24 and reject in 31. Writing it with bit 16 = 0 starts a local read. A local write starts when 0x04 is written while the word holds write and is not rejected. Local requests drive dn_req_local = 1, the dword-aligned offset as address, and command 0x0 (read) or 0x1 (write).
- R7: Write data is forwarded on dn_req_wdata unchanged. A successful read response is stored whole in 0x18 (bus path) or 0x08 (local path).
- R8: dn_req_valid is high for exactly one cycle per accepted request. busy, which also reads as bit 8 of 0x1C, stays high from that cycle until the cycle after dn_rsp_valid is sampled. A response while idle is ignored.
- R9: A response with dn_rsp_abort set sets bit 0 of 0x1C and latches the request address into 0x20. On a read it also writes 0xFFFFFFFF into the path's read-data register.
- R10: While busy, writes to 0x00, 0x04, 0x10 or 0x14 leave those registers unchanged and start nothing. They set bit 1 of 0x1C and latch the in-flight address into 0x20.
- R11: A fab_err_valid pulse sets bit 0 of 0x24 and latches fab_err_addr into 0x28.
- R12: Writing 1 to a status bit at 0x1C or 0x24 clears it, and writing 0 leaves it. If a new error and a clear hit the same bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| dn_req_valid | output | 1 | One-cycle request pulse |
| dn_req_local | output | 1 | 1 = local configuration space |
| dn_req_write | output | 1 | 1 = write transaction |
| dn_req_cmd | output | 4 | Request command code |
| dn_req_addr | output | 32 | Request address |
| dn_req_be_n | output | 4 | Active-low byte enables |
| dn_req_wdata | output | 32 | Lane-aligned write data |
| dn_rsp_valid | input | 1 | Response strobe |
| dn_rsp_abort | input | 1 | Response ended in master abort |
| dn_rsp_rdata | input | 32 | Response read data |
| fab_err_valid | input | 1 | Local fabric error pulse |
| fab_err_addr | input | 32 | Address of the fabric error |
| busy | output | 1 | Transaction outstanding |

## Verification
The assertions assume two things. Reset is held for at least one clock edge. A response strobe lasts a single cycle and never comes in the same cycle as the request it answers. They do not assume the responder stays silent while idle. The bench's responder therefore waits until it has seen dn_req_valid before pulsing dn_rsp_valid for one cycle. The only exception is one deliberate idle pulse, sent to show that such a pulse has no effect. Register strobes are driven one at a time, away from the clock edge. The only cycle that carries an error input and a clear together is the one that tests set-over-clear priority.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam int unsigned DW = 32;

  localparam int unsigned OFF_LOC_CTRL  = 'h00;
  localparam int unsigned OFF_LOC_WD    = 'h04;
  localparam int unsigned OFF_LOC_RD    = 'h08;
  localparam int unsigned OFF_CFG_ADDR  = 'h0C;
  localparam int unsigned OFF_CFG_CMD   = 'h10;
  localparam int unsigned OFF_CFG_WD    = 'h14;
  localparam int unsigned OFF_CFG_RD    = 'h18;
  localparam int unsigned OFF_BUS_ERR   = 'h1C;
  localparam int unsigned OFF_BUS_EADDR = 'h20;
  localparam int unsigned OFF_FAB_ERR   = 'h24;
  localparam int unsigned OFF_FAB_EADDR = 'h28;

  localparam logic [3:0] CMD_CFG_RD = 4'hA;
  localparam logic [3:0] CMD_CFG_WR = 4'hB;
  localparam logic [3:0] CMD_LOC_RD = 4'h0;
  localparam logic [3:0] CMD_LOC_WR = 4'h1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef struct packed {
    logic       rej;
    size_e      size;
    logic [3:0] be_n;
    logic [3:0] cmd;
  } cfg_cmd_t;

  typedef struct packed {
    logic       rej;
    size_e      size;
    logic [3:0] be_n;
    logic       wr;
    logic [5:0] dw_off;
  } loc_ctrl_t;
endpackage

// File: rtl/pcfg_be_gen.sv
module pcfg_be_gen
  import pcfg_pkg::*;
(
  input  size_e      size,
  input  logic [1:0] off,
  output logic [3:0] be_n,
  output logic       illegal
);
  always_comb begin
    be_n    = 4'hF;
    illegal = 1'b1;
    case (size)
      SZ_BYTE: begin
        illegal = 1'b0;
        case (off)
          2'd0:    be_n = 4'hE;
          2'd1:    be_n = 4'hD;
          2'd2:    be_n = 4'hB;
          default: be_n = 4'h7;
        endcase
      end
      SZ_HALF: begin
        if (off == 2'd0) begin
          be_n    = 4'hC;
          illegal = 1'b0;
        end else if (off == 2'd2) begin
          be_n    = 4'h3;
          illegal = 1'b0;
        end
      end
      SZ_WORD: begin
        if (off == 2'd0) begin
          be_n    = 4'h0;
          illegal = 1'b0;
        end
      end
      default: ;
    endcase
  end

  // R2: a legal access enables one, two or four lanes
  always_comb begin
    a_r2_lane_count: assert (illegal || ($countones(~be_n) == 1) ||
                             ($countones(~be_n) == 2) || ($countones(~be_n) == 4));
  end
endmodule

// File: rtl/pcfg_addr_fmt.sv
module pcfg_addr_fmt
  import pcfg_pkg::*;
(
  input  logic [23:0]   locator,
  output logic [DW-1:0] bus_addr
);
  logic [7:0] bus_no;
  logic [4:0] dev_no;
  logic [2:0] fn_no;
  logic [5:0] dw_no;

  assign bus_no = locator[23:16];
  assign dev_no = locator[15:11];
  assign fn_no  = locator[10:8];
  assign dw_no  = locator[7:2];

  always_comb begin
    if (bus_no == 8'd0) begin
      bus_addr = (DW'(1) << dev_no) | {21'd0, fn_no, dw_no, 2'b00};
    end else begin
      bus_addr = {8'd0, bus_no, dev_no, fn_no, dw_no, 2'b01};
    end
  end
endmodule

// File: rtl/pcfg_err_stat.sv
module pcfg_err_stat
  import pcfg_pkg::*;
#(
  parameter int unsigned W = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  set,
  input  logic [DW-1:0] set_addr,
  input  logic          clr_we,
  input  logic [W-1:0]  clr_bits,
  output logic [W-1:0]  status,
  output logic [DW-1:0] addr
);
  logic [W-1:0] clr_mask;
  assign clr_mask = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      addr   <= '0;
    end else begin
      status <= (status & ~clr_mask) | set;
      if (|set) addr <= set_addr;
    end
  end

  // R12: a raised error survives a same-cycle clear
  a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|set) |=> ((status & $past(set)) == $past(set)));

  // R12: writing ones clears when nothing new is raised
  a_r12_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !(|set)) |=> ((status & $past(clr_bits)) == '0));

  // R9 / R11: a raised error latches its address
  a_r11_addr_latch: assert property (@(posedge clk) disable iff (rst)
    (|set) |=> (addr == $past(set_addr)));
endmodule

// File: rtl/pcfg_req_top.sv
module pcfg_req_top
  import pcfg_pkg::*;
#(
  parameter int unsigned REG_AW    = 6,
  parameter int unsigned BUS_ERR_W = 2,
  parameter int unsigned FAB_ERR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              dn_req_valid,
  output logic              dn_req_local,
  output logic              dn_req_write,
  output logic [3:0]        dn_req_cmd,
  output logic [DW-1:0]     dn_req_addr,
  output logic [3:0]        dn_req_be_n,
  output logic [DW-1:0]     dn_req_wdata,
  input  logic              dn_rsp_valid,
  input  logic              dn_rsp_abort,
  input  logic [DW-1:0]     dn_rsp_rdata,
  input  logic              fab_err_valid,
  input  logic [DW-1:0]     fab_err_addr,
  output logic              busy
);
  localparam logic [REG_AW-1:0] A_LC  = REG_AW'(OFF_LOC_CTRL);
  localparam logic [REG_AW-1:0] A_LW  = REG_AW'(OFF_LOC_WD);
  localparam logic [REG_AW-1:0] A_LR  = REG_AW'(OFF_LOC_RD);
  localparam logic [REG_AW-1:0] A_CA  = REG_AW'(OFF_CFG_ADDR);
  localparam logic [REG_AW-1:0] A_CC  = REG_AW'(OFF_CFG_CMD);
  localparam logic [REG_AW-1:0] A_CW  = REG_AW'(OFF_CFG_WD);
  localparam logic [REG_AW-1:0] A_CR  = REG_AW'(OFF_CFG_RD);
  localparam logic [REG_AW-1:0] A_BE  = REG_AW'(OFF_BUS_ERR);
  localparam logic [REG_AW-1:0] A_BEA = REG_AW'(OFF_BUS_EADDR);
  localparam logic [REG_AW-1:0] A_FE  = REG_AW'(OFF_FAB_ERR);
  localparam logic [REG_AW-1:0] A_FEA = REG_AW'(OFF_FAB_EADDR);
  localparam int unsigned BUSY_BIT = 8;

  loc_ctrl_t     loc_ctrl_q;
  cfg_cmd_t      cfg_cmd_q;
  logic [DW-1:0] cfg_addr_q;
  logic [DW-1:0] loc_wd_q, loc_rd_q, cfg_wd_q, cfg_rd_q;

  logic hit_lc, hit_lw, hit_ca, hit_cc, hit_cw, hit_be, hit_fe;
  logic blocked, rsp_take;
  logic start_cr, start_cw, start_lr, start_lw;

  logic [3:0]    cc_be_n, lc_be_n;
  logic          cc_illegal, lc_illegal;
  logic [DW-1:0] cfg_bus_addr;

  logic [BUS_ERR_W-1:0] bus_set, bus_st;
  logic [FAB_ERR_W-1:0] fab_set, fab_st;
  logic [DW-1:0]        bus_eaddr, fab_eaddr;
  logic [DW-1:0]        rd_mux;

  // lane decoders, one per request path
  pcfg_be_gen u_be_cfg (
    .size    (size_e'(reg_wdata[9:8])),
    .off     (cfg_addr_q[1:0]),
    .be_n    (cc_be_n),
    .illegal (cc_illegal)
  );

  pcfg_be_gen u_be_loc (
    .size    (size_e'(reg_wdata[25:24])),
    .off     (reg_wdata[1:0]),
    .be_n    (lc_be_n),
    .illegal (lc_illegal)
  );

  pcfg_addr_fmt u_fmt (
    .locator  (cfg_addr_q[23:0]),
    .bus_addr (cfg_bus_addr)
  );

  // write decode and transaction start conditions
  always_comb begin
    hit_lc = reg_wr && (reg_addr == A_LC);
    hit_lw = reg_wr && (reg_addr == A_LW);
    hit_ca = reg_wr && (reg_addr == A_CA);
    hit_cc = reg_wr && (reg_addr == A_CC);
    hit_cw = reg_wr && (reg_addr == A_CW);
    hit_be = reg_wr && (reg_addr == A_BE);
    hit_fe = reg_wr && (reg_addr == A_FE);

    blocked  = busy && (hit_lc || hit_lw || hit_cc || hit_cw);
    rsp_take = dn_rsp_valid && busy;

    start_cr = hit_cc && !busy && !cc_illegal && (reg_wdata[3:0] == CMD_CFG_RD);
    start_cw = hit_cw && !busy && (cfg_cmd_q.cmd == CMD_CFG_WR) && !cfg_cmd_q.rej;
    start_lr = hit_lc && !busy && !lc_illegal && !reg_wdata[16];
    start_lw = hit_lw && !busy && loc_ctrl_q.wr && !loc_ctrl_q.rej;
  end

  // programming registers
  always_ff @(posedge clk) begin
    if (rst) begin
      loc_ctrl_q <= '0;
      cfg_cmd_q  <= '0;
      cfg_addr_q <= '0;
      loc_wd_q   <= '0;
      cfg_wd_q   <= '0;
    end else begin
      if (hit_lc && !busy) begin
        loc_ctrl_q.rej    <= lc_illegal;
        loc_ctrl_q.size   <= size_e'(reg_wdata[25:24]);
        loc_ctrl_q.be_n   <= lc_be_n;
        loc_ctrl_q.wr     <= reg_wdata[16];
        loc_ctrl_q.dw_off <= reg_wdata[7:2];
      end
      if (hit_cc && !busy) begin
        cfg_cmd_q.rej  <= cc_illegal;
        cfg_cmd_q.size <= size_e'(reg_wdata[9:8]);
        cfg_cmd_q.be_n <= cc_be_n;
        cfg_cmd_q.cmd  <= reg_wdata[3:0];
      end
      if (hit_ca)           cfg_addr_q <= reg_wdata;
      if (hit_lw && !busy)  loc_wd_q   <= reg_wdata;
      if (hit_cw && !busy)  cfg_wd_q   <= reg_wdata;
    end
  end

  // downstream request and response tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      dn_req_valid <= 1'b0;
      dn_req_local <= 1'b0;
      dn_req_write <= 1'b0;
      dn_req_cmd   <= '0;
      dn_req_addr  <= '0;
      dn_req_be_n  <= 4'hF;
      dn_req_wdata <= '0;
      loc_rd_q     <= '0;
      cfg_rd_q     <= '0;
    end else begin
      dn_req_valid <= 1'b0;
      if (start_cr) begin
        busy         <= 1'b1;
        dn_req_valid <= 1'b1;
        dn_req_local <= 1'b0;
        dn_req_write <= 1'b0;
        dn_req_cmd   <= CMD_CFG_RD;
        dn_req_addr  <= cfg_bus_addr;
        dn_req_be_n  <= cc_be_n;
        dn_req_wdata <= '0;
      end else if (start_cw) begin
        busy         <= 1'b1;
        dn_req_valid <= 1'b1;
        dn_req_local <= 1'b0;
        dn_req_write <= 1'b1;
        dn_req_cmd   <= CMD_CFG_WR;
        dn_req_addr  <= cfg_bus_addr;
        dn_req_be_n  <= cfg_cmd_q.be_n;
        dn_req_wdata <= reg_wdata;
      end else if (start_lr) begin
        busy         <= 1'b1;
        dn_req_valid <= 1'b1;
        dn_req_local <= 1'b1;
        dn_req_write <= 1'b0;
        dn_req_cmd   <= CMD_LOC_RD;
        dn_req_addr  <= {24'd0, reg_wdata[7:2], 2'b00};
        dn_req_be_n  <= lc_be_n;
        dn_req_wdata <= '0;
      end else if (start_lw) begin
        busy         <= 1'b1;
        dn_req_valid <= 1'b1;
        dn_req_local <= 1'b1;
        dn_req_write <= 1'b1;
        dn_req_cmd   <= CMD_LOC_WR;
        dn_req_addr  <= {24'd0, loc_ctrl_q.dw_off, 2'b00};
        dn_req_be_n  <= loc_ctrl_q.be_n;
        dn_req_wdata <= reg_wdata;
      end else if (rsp_take) begin
        busy <= 1'b0;
        if (!dn_req_write) begin
          if (dn_req_local) loc_rd_q <= dn_rsp_abort ? '1 : dn_rsp_rdata;
          else              cfg_rd_q <= dn_rsp_abort ? '1 : dn_rsp_rdata;
        end
      end
    end
  end

  // error status: bit 0 master abort, bit 1 request while busy
  always_comb begin
    bus_set    = '0;
    bus_set[0] = rsp_take && dn_rsp_abort;
    bus_set[1] = blocked;
    fab_set    = '0;
    fab_set[0] = fab_err_valid;
  end

  pcfg_err_stat #(.W(BUS_ERR_W)) u_bus_err (
    .clk      (clk),
    .rst      (rst),
    .set      (bus_set),
    .set_addr (dn_req_addr),
    .clr_we   (hit_be),
    .clr_bits (reg_wdata[BUS_ERR_W-1:0]),
    .status   (bus_st),
    .addr     (bus_eaddr)
  );

  pcfg_err_stat #(.W(FAB_ERR_W)) u_fab_err (
    .clk      (clk),
    .rst      (rst),
    .set      (fab_set),
    .set_addr (fab_err_addr),
    .clr_we   (hit_fe),
    .clr_bits (reg_wdata[FAB_ERR_W-1:0]),
    .status   (fab_st),
    .addr     (fab_eaddr)
  );

  // register read path
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_LC:  rd_mux = {loc_ctrl_q.rej, 5'd0, loc_ctrl_q.size, loc_ctrl_q.be_n,
                       3'd0, loc_ctrl_q.wr, 8'd0, loc_ctrl_q.dw_off, 2'b00};
      A_LW:  rd_mux = loc_wd_q;
      A_LR:  rd_mux = loc_rd_q;
      A_CA:  rd_mux = cfg_addr_q;
      A_CC:  rd_mux = {16'd0, cfg_cmd_q.rej, 5'd0, cfg_cmd_q.size,
                       cfg_cmd_q.be_n, cfg_cmd_q.cmd};
      A_CW:  rd_mux = cfg_wd_q;
      A_CR:  rd_mux = cfg_rd_q;
      A_BE:  rd_mux = DW'(bus_st) | (DW'(busy) << BUSY_BIT);
      A_BEA: rd_mux = bus_eaddr;
      A_FE:  rd_mux = DW'(fab_st);
      A_FEA: rd_mux = fab_eaddr;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R8: request strobe lasts one cycle
  a_r8_req_one_cycle: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid |=> !dn_req_valid);

  // R8: a request is always accompanied by busy
  a_r8_req_busy: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid |-> busy);

  // R10: the in-flight request stays put until answered
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !dn_rsp_valid) |=> (busy && $stable(dn_req_addr)));

  // R10: command register is frozen while busy
  a_r10_cmd_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && hit_cc) |=> $stable(cfg_cmd_q));

  // R9: an aborted bus read yields all ones
  a_r9_all_ones: assert property (@(posedge clk) disable iff (rst)
    (dn_rsp_valid && busy && dn_rsp_abort && !dn_req_write && !dn_req_local)
    |=> (cfg_rd_q == '1));
endmodule

// File: tb/pcfg_req_top_tb.sv
`timescale 1ns/1ps
module pcfg_req_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dn_req_valid, dn_req_local, dn_req_write;
  logic [3:0]  dn_req_cmd, dn_req_be_n;
  logic [31:0] dn_req_addr, dn_req_wdata;
  logic        dn_rsp_valid = 1'b0, dn_rsp_abort = 1'b0;
  logic [31:0] dn_rsp_rdata = '0;
  logic        fab_err_valid = 1'b0;
  logic [31:0] fab_err_addr = '0;
  logic        busy;

  int checks = 0;
  int errors = 0;

  logic        seen, c_local, c_write;
  logic [3:0]  c_cmd, c_be;
  logic [31:0] c_addr, c_wdata;

  always #2.5 clk = ~clk;

  pcfg_req_top dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dn_req_valid(dn_req_valid),
    .dn_req_local(dn_req_local), .dn_req_write(dn_req_write), .dn_req_cmd(dn_req_cmd),
    .dn_req_addr(dn_req_addr), .dn_req_be_n(dn_req_be_n), .dn_req_wdata(dn_req_wdata),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_abort(dn_rsp_abort), .dn_rsp_rdata(dn_rsp_rdata),
    .fab_err_valid(fab_err_valid), .fab_err_addr(fab_err_addr), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    seen = dn_req_valid; c_local = dn_req_local; c_write = dn_req_write;
    c_cmd = dn_req_cmd; c_be = dn_req_be_n; c_addr = dn_req_addr; c_wdata = dn_req_wdata;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rsp(input logic ab, input logic [31:0] d);
    @(negedge clk);
    dn_rsp_valid = 1'b1; dn_rsp_abort = ab; dn_rsp_rdata = d;
    @(posedge clk); #1;
    @(negedge clk);
    dn_rsp_valid = 1'b0; dn_rsp_abort = 1'b0;
  endtask

  function automatic logic legal(int sz, int off);
    return (sz < 3) && ((off % (1 << sz)) == 0);
  endfunction

  function automatic logic [3:0] exp_be(int sz, int off);
    logic [3:0] m;
    m = (sz == 0) ? 4'h1 : (sz == 1) ? 4'h3 : 4'hF;
    return ~(m << off);
  endfunction

  function automatic logic [31:0] exp_addr(int bus, int dev, int fn, int where);
    if (bus == 0) return (32'd1 << dev) | (32'(fn) << 8) | (32'(where) & 32'hFC);
    return (32'(bus) << 16) | (32'(dev) << 11) | (32'(fn) << 8) | (32'(where) & 32'hFC) | 32'd1;
  endfunction

  function automatic logic [31:0] loc(int bus, int dev, int fn, int where);
    return (32'(bus) << 16) | (32'(dev) << 11) | (32'(fn) << 8) | 32'(where);
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog expired got=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, cap;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 req", 32'(dn_req_valid), 0);
    rd(6'h1C, v); chk("R1 bus status", v, 0);
    rd(6'h10, v); chk("R1 cmd reg", v, 0);
    rd(6'h00, v); chk("R1 local ctrl", v, 0);
    rd(6'h24, v); chk("R1 fab status", v, 0);

    // R2 / R7: bus path size x offset sweep
    for (int sz = 0; sz < 4; sz++) begin
      for (int off = 0; off < 4; off++) begin
        wr(6'h0C, loc(0, 3, 0, 8'h40 + off));
        wr(6'h10, (32'(sz) << 8) | 32'hA);
        if (legal(sz, off)) begin
          chk("R2 cfg req", 32'(seen), 1);
          chk("R2 cfg be", 32'(c_be), 32'(exp_be(sz, off)));
          chk("R4 cfg addr", c_addr, exp_addr(0, 3, 0, 8'h40));
          rsp(1'b0, 32'hC0DE0000 + 32'(sz * 4 + off));
          rd(6'h18, v); chk("R7 cfg rdata", v, 32'hC0DE0000 + 32'(sz * 4 + off));
          rd(6'h10, v); chk("R2 cfg readback", v, (32'(sz) << 8) | (32'(exp_be(sz, off)) << 4) | 32'hA);
        end else begin
          chk("R2 cfg reject no req", 32'(seen), 0);
          rd(6'h10, v); chk("R2 cfg reject flag", 32'(v[15]), 1);
        end
      end
    end

    // R2 / R6 / R7: local path sweep
    for (int sz = 0; sz < 4; sz++) begin
      for (int off = 0; off < 4; off++) begin
        wr(6'h00, (32'(sz) << 24) | 32'(8'h20 + off));
        if (legal(sz, off)) begin
          chk("R6 loc req", 32'(seen), 1);
          chk("R6 loc local", 32'(c_local), 1);
          chk("R6 loc cmd", 32'(c_cmd), 0);
          chk("R6 loc addr", c_addr, 32'h20);
          chk("R2 loc be", 32'(c_be), 32'(exp_be(sz, off)));
          rsp(1'b0, 32'h5A000000 + 32'(sz * 4 + off));
          rd(6'h08, v); chk("R7 loc rdata", v, 32'h5A000000 + 32'(sz * 4 + off));
          rd(6'h00, v); chk("R6 loc readback", v, (32'(sz) << 24) | (32'(exp_be(sz, off)) << 20) | 32'h20);
        end else begin
          chk("R2 loc reject no req", 32'(seen), 0);
          rd(6'h00, v); chk("R2 loc reject flag", 32'(v[31]), 1);
        end
      end
    end

    // R4: type-0 sweep
    for (int dev = 0; dev < 21; dev++) begin
      wr(6'h0C, loc(0, dev, dev % 8, (dev * 4) & 8'hFC));
      wr(6'h10, 32'h20A);
      chk("R4 type0 addr", c_addr, exp_addr(0, dev, dev % 8, (dev * 4) & 8'hFC));
      rsp(1'b0, 32'h0);
    end

    // R5: type-1 sweep
    for (int b = 0; b < 3; b++) begin
      for (int d = 0; d < 3; d++) begin
        int bus, dev, fn;
        bus = (b == 0) ? 1 : (b == 1) ? 7 : 255;
        dev = (d == 0) ? 0 : (d == 1) ? 5 : 31;
        fn  = (b + d) % 8;
        wr(6'h0C, loc(bus, dev, fn, 8'hFC));
        wr(6'h10, 32'h20A);
        chk("R5 type1 addr", c_addr, exp_addr(bus, dev, fn, 8'hFC));
        rsp(1'b0, 32'h0);
      end
    end

    // R3: other command codes start nothing; bus write needs data write
    wr(6'h10, 32'h205);
    chk("R3 cmd 5 no req", 32'(seen), 0);
    wr(6'h14, 32'h11111111);
    chk("R3 wdata without write cmd", 32'(seen), 0);
    wr(6'h0C, loc(0, 2, 1, 8'h12));
    wr(6'h10, 32'h10B);
    chk("R3 write cmd alone", 32'(seen), 0);
    wr(6'h14, 32'hABCD0000);
    chk("R3 write req", 32'(seen), 1);
    chk("R3 write cmd", 32'(c_cmd), 32'hB);
    chk("R3 write flag", 32'(c_write), 1);
    chk("R3 write be", 32'(c_be), 32'h3);
    chk("R7 write data", c_wdata, 32'hABCD0000);
    chk("R8 busy during", 32'(busy), 1);
    rd(6'h1C, v); chk("R8 busy bit", v, 32'h100);
    rsp(1'b0, 32'h0);
    chk("R8 busy after rsp", 32'(busy), 0);

    // R6: local write
    wr(6'h00, 32'h0201_0010);
    chk("R6 loc write ctrl alone", 32'(seen), 0);
    wr(6'h04, 32'h00C0FFEE);
    chk("R6 loc write req", 32'(seen), 1);
    chk("R6 loc write local", 32'(c_local), 1);
    chk("R6 loc write cmd", 32'(c_cmd), 1);
    chk("R6 loc write be", 32'(c_be), 0);
    chk("R7 loc write data", c_wdata, 32'h00C0FFEE);
    rsp(1'b0, 32'h0);

    // R8: idle response ignored
    rd(6'h18, cap);
    rsp(1'b0, 32'hDEADBEEF);
    rd(6'h18, v); chk("R8 idle rsp ignored", v, cap);
    chk("R8 idle busy", 32'(busy), 0);

    // R9 / R12: abort on read
    wr(6'h0C, loc(0, 4, 2, 8'h08));
    wr(6'h10, 32'h20A);
    cap = c_addr;
    rsp(1'b1, 32'h12345678);
    rd(6'h18, v); chk("R9 abort all ones", v, 32'hFFFFFFFF);
    rd(6'h1C, v); chk("R9 abort status", v, 32'h1);
    rd(6'h20, v); chk("R9 abort addr", v, cap);
    wr(6'h1C, 32'h0);
    rd(6'h1C, v); chk("R12 write zero keeps", v, 32'h1);
    wr(6'h1C, 32'h1);
    rd(6'h1C, v); chk("R12 write one clears", v, 32'h0);

    // R10: collision while busy
    wr(6'h0C, loc(3, 9, 1, 8'h40));
    wr(6'h10, 32'h20A);
    cap = c_addr;
    wr(6'h10, 32'h20B);
    chk("R10 blocked no req", 32'(seen), 0);
    wr(6'h00, 32'h0001_0004);
    rsp(1'b0, 32'h0);
    rd(6'h10, v); chk("R10 cmd unchanged", v, 32'h20A);
    rd(6'h00, v); chk("R10 ctrl unchanged", v, 32'h0201_0010);
    rd(6'h1C, v); chk("R10 status", v, 32'h2);
    rd(6'h20, v); chk("R10 addr", v, cap);
    wr(6'h1C, 32'h2);
    rd(6'h1C, v); chk("R12 clear bit1", v, 32'h0);

    // R11: fabric error
    @(negedge clk); fab_err_valid = 1'b1; fab_err_addr = 32'h8000_1234;
    @(negedge clk); fab_err_valid = 1'b0;
    rd(6'h24, v); chk("R11 fab status", v, 32'h1);
    rd(6'h28, v); chk("R11 fab addr", v, 32'h8000_1234);
    wr(6'h24, 32'h1);
    rd(6'h24, v); chk("R12 fab clear", v, 32'h0);

    // R12: set wins over same-cycle clear
    @(negedge clk);
    fab_err_valid = 1'b1; fab_err_addr = 32'h55;
    reg_wr = 1'b1; reg_addr = 6'h24; reg_wdata = 32'h1;
    @(negedge clk);
    fab_err_valid = 1'b0; reg_wr = 1'b0;
    rd(6'h24, v); chk("R12 set wins", v, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule